// File: doc/BRIEF.md
# Framebuffer Mode Geometry Validator

This block sits behind the mode registers of a linear-framebuffer display controller. Each cycle it takes the raw register values (enable word, bits per pixel, visible width and height, virtual line width, X and Y panning offsets, a byte-order select) and the size of the video memory. From these it derives the pixel format, bytes per pixel, line stride, byte offset of the first visible pixel and the byte size of the visible surface. It then decides whether the combination can be scanned out.

Every result is registered, so the outputs show the inputs sampled at the previous rising clock edge. A surface that fails any check is reported as all-zero geometry with the valid flag low. A zero size is the sign that no mode is active. The block also keeps a copy of the last accepted mode. When a new valid mode differs from that copy in any field, it raises a one-cycle change strobe and takes the new mode as its copy. A consumer such as a scan-out engine uses the strobe to rebuild its surface description.

Top module: `fbmode_validator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is zero. This includes the valid flag and the change strobe.
- R2: The mode is invalid when bit 0 of the enable word is clear. Other bits of that word have no effect.
- R3: A bits-per-pixel value of 16 gives format code 1 with 2 bytes per pixel. A value of 32 gives 4 bytes per pixel, with format code 2 when the byte-order input is low and code 3 when it is high.
- R4: Any bits-per-pixel value other than 16 or 32 makes the mode invalid.
- R5: The effective line width is the virtual width, raised to the visible width when it is smaller. The stride is the effective line width times bytes per pixel.
- R6: The surface size is the stride times the visible height.
- R7: The start offset is the X offset times bytes per pixel, plus the Y offset times the stride.
- R8: The mode is invalid when the width or the height is below 64. A value of exactly 64 is accepted.
- R9: The mode is invalid when the start offset plus the size is greater than the video memory size. Exactly filling the memory is accepted.
- R10: For an invalid mode, format, bytes per pixel, width, height, stride, offset and size all read zero and the valid flag is low.
- R11: The change strobe is high for one cycle only when a valid mode differs from the last accepted mode, which it then replaces. A repeated mode, an invalid mode, or a return to the accepted mode after invalid cycles gives no strobe.
- R12: All outputs follow the inputs with exactly one clock of latency, so a new input set each cycle gives a new result each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_word_i | input | REG_W | Enable word; bit 0 turns the display on |
| bpp_i | input | REG_W | Bits per pixel |
| xres_i | input | REG_W | Visible width in pixels |
| yres_i | input | REG_W | Visible height in lines |
| vwidth_i | input | REG_W | Virtual line width in pixels |
| xoff_i | input | REG_W | Horizontal panning offset in pixels |
| yoff_i | input | REG_W | Vertical panning offset in lines |
| be_order_i | input | 1 | Byte-order select for 32-bit pixels (1 = big endian) |
| vmem_bytes_i | input | CALC_W | Video memory size in bytes |
| fmt_o | output | 2 | Format code: 0 none, 1 RGB565, 2 xRGB little endian, 3 xRGB big endian |
| bytes_pp_o | output | 3 | Bytes per pixel |
| width_o | output | REG_W | Accepted visible width |
| height_o | output | REG_W | Accepted visible height |
| stride_o | output | CALC_W | Line stride in bytes |
| offset_o | output | CALC_W | Byte offset of the first visible pixel |
| size_o | output | CALC_W | Surface size in bytes |
| mode_ok_o | output | 1 | Mode is usable |
| mode_chg_o | output | 1 | One-cycle strobe on a new valid mode |

## Verification
A corrupted copy of the accepted mode only shows up on the strobe. It shows as a strobe that fires again for an unchanged mode, or as a missing strobe when the mode changes. It is visible one cycle after the inputs that expose it, and only when a valid mode is presented. Errors in the arithmetic or the checks show directly on the geometry outputs, also one cycle after the inputs. A wrong validity decision shows either as nonzero fields with the valid flag low or as a valid flag on a surface that breaks the size rules. The scenarios therefore present the same mode again, move between valid and invalid modes, and step across each boundary to catch these faults.

// File: rtl/fbv_pkg.sv
package fbv_pkg;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_RGB565 = 2'd1,
        FMT_XRGB_L = 2'd2,
        FMT_XRGB_B = 2'd3
    } fbv_fmt_e;

    localparam int unsigned BPP_SHORT = 16;
    localparam int unsigned BPP_WIDE  = 32;

endpackage

// File: rtl/fbv_fmt_decode.sv
module fbv_fmt_decode
    import fbv_pkg::*;
#(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned EN_BIT = 0
) (
    input  logic [REG_W-1:0] en_word_i,
    input  logic [REG_W-1:0] bpp_i,
    input  logic             be_order_i,
    output fbv_fmt_e         fmt_o,
    output logic [2:0]       bytes_o,
    output logic             usable_o
);

    logic enabled;

    always_comb begin
        enabled = en_word_i[EN_BIT];
        fmt_o   = FMT_NONE;
        bytes_o = 3'd0;
        if (bpp_i == REG_W'(BPP_SHORT)) begin
            fmt_o   = FMT_RGB565;
            bytes_o = 3'd2;
        end else if (bpp_i == REG_W'(BPP_WIDE)) begin
            fmt_o   = be_order_i ? FMT_XRGB_B : FMT_XRGB_L;
            bytes_o = 3'd4;
        end
        usable_o = enabled && (bytes_o != 3'd0);
    end

endmodule

// File: rtl/fbv_geom_math.sv
module fbv_geom_math #(
    parameter int unsigned REG_W   = 16,
    parameter int unsigned CALC_W  = 64,
    parameter int unsigned MIN_DIM = 64
) (
    input  logic [2:0]        bytes_i,
    input  logic [REG_W-1:0]  xres_i,
    input  logic [REG_W-1:0]  yres_i,
    input  logic [REG_W-1:0]  vwidth_i,
    input  logic [REG_W-1:0]  xoff_i,
    input  logic [REG_W-1:0]  yoff_i,
    input  logic [CALC_W-1:0] vmem_bytes_i,
    output logic [CALC_W-1:0] stride_o,
    output logic [CALC_W-1:0] size_o,
    output logic [CALC_W-1:0] offset_o,
    output logic              dims_ok_o,
    output logic              fits_o
);

    localparam int unsigned PAD_W = CALC_W - REG_W;

    logic [REG_W-1:0]  eff_w;
    logic [CALC_W-1:0] eff_w_x;
    logic [CALC_W-1:0] height_x;
    logic [CALC_W-1:0] xoff_x;
    logic [CALC_W-1:0] yoff_x;
    logic [CALC_W-1:0] bytes_x;
    logic [CALC_W-1:0] end_x;

    always_comb begin
        eff_w     = (vwidth_i < xres_i) ? xres_i : vwidth_i;
        eff_w_x   = {{PAD_W{1'b0}}, eff_w};
        height_x  = {{PAD_W{1'b0}}, yres_i};
        xoff_x    = {{PAD_W{1'b0}}, xoff_i};
        yoff_x    = {{PAD_W{1'b0}}, yoff_i};
        bytes_x   = CALC_W'(bytes_i);
        stride_o  = eff_w_x * bytes_x;
        size_o    = stride_o * height_x;
        offset_o  = (xoff_x * bytes_x) + (yoff_x * stride_o);
        end_x     = offset_o + size_o;
        dims_ok_o = (xres_i >= REG_W'(MIN_DIM)) && (yres_i >= REG_W'(MIN_DIM));
        fits_o    = (end_x <= vmem_bytes_i);
    end

endmodule

// File: rtl/fbv_mode_track.sv
module fbv_mode_track #(
    parameter int unsigned MODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              chg_o
);

    typedef struct packed {
        logic [MODE_W-1:0] held;
        logic              chg;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.chg = 1'b0;
        if (valid_i && (mode_i != trk_q.held)) begin
            trk_d.chg  = 1'b1;
            trk_d.held = mode_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign chg_o = trk_q.chg;

endmodule

// File: rtl/fbmode_validator.sv
module fbmode_validator
    import fbv_pkg::*;
#(
    parameter int unsigned REG_W   = 16,
    parameter int unsigned CALC_W  = 64,
    parameter int unsigned MIN_DIM = 64,
    parameter int unsigned EN_BIT  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_W-1:0]  en_word_i,
    input  logic [REG_W-1:0]  bpp_i,
    input  logic [REG_W-1:0]  xres_i,
    input  logic [REG_W-1:0]  yres_i,
    input  logic [REG_W-1:0]  vwidth_i,
    input  logic [REG_W-1:0]  xoff_i,
    input  logic [REG_W-1:0]  yoff_i,
    input  logic              be_order_i,
    input  logic [CALC_W-1:0] vmem_bytes_i,
    output logic [1:0]        fmt_o,
    output logic [2:0]        bytes_pp_o,
    output logic [REG_W-1:0]  width_o,
    output logic [REG_W-1:0]  height_o,
    output logic [CALC_W-1:0] stride_o,
    output logic [CALC_W-1:0] offset_o,
    output logic [CALC_W-1:0] size_o,
    output logic              mode_ok_o,
    output logic              mode_chg_o
);

    typedef struct packed {
        fbv_fmt_e          fmt;
        logic [2:0]        bytes;
        logic [REG_W-1:0]  width;
        logic [REG_W-1:0]  height;
        logic [CALC_W-1:0] stride;
        logic [CALC_W-1:0] offset;
        logic [CALC_W-1:0] size;
    } geom_t;

    localparam int unsigned MODE_W = $bits(geom_t);

    typedef struct packed {
        geom_t geom;
        logic  ok;
    } out_t;

    out_t out_d, out_q;

    fbv_fmt_e          dec_fmt;
    logic [2:0]        dec_bytes;
    logic              dec_usable;
    logic [CALC_W-1:0] m_stride;
    logic [CALC_W-1:0] m_size;
    logic [CALC_W-1:0] m_offset;
    logic              m_dims_ok;
    logic              m_fits;
    logic              trk_chg;

    fbv_fmt_decode #(
        .REG_W  (REG_W),
        .EN_BIT (EN_BIT)
    ) u_dec (
        .en_word_i  (en_word_i),
        .bpp_i      (bpp_i),
        .be_order_i (be_order_i),
        .fmt_o      (dec_fmt),
        .bytes_o    (dec_bytes),
        .usable_o   (dec_usable)
    );

    fbv_geom_math #(
        .REG_W   (REG_W),
        .CALC_W  (CALC_W),
        .MIN_DIM (MIN_DIM)
    ) u_math (
        .bytes_i      (dec_bytes),
        .xres_i       (xres_i),
        .yres_i       (yres_i),
        .vwidth_i     (vwidth_i),
        .xoff_i       (xoff_i),
        .yoff_i       (yoff_i),
        .vmem_bytes_i (vmem_bytes_i),
        .stride_o     (m_stride),
        .size_o       (m_size),
        .offset_o     (m_offset),
        .dims_ok_o    (m_dims_ok),
        .fits_o       (m_fits)
    );

    always_comb begin
        out_d = '0;
        if (dec_usable && m_dims_ok && m_fits) begin
            out_d.ok          = 1'b1;
            out_d.geom.fmt    = dec_fmt;
            out_d.geom.bytes  = dec_bytes;
            out_d.geom.width  = xres_i;
            out_d.geom.height = yres_i;
            out_d.geom.stride = m_stride;
            out_d.geom.offset = m_offset;
            out_d.geom.size   = m_size;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    fbv_mode_track #(
        .MODE_W (MODE_W)
    ) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (out_d.ok),
        .mode_i  (out_d.geom),
        .chg_o   (trk_chg)
    );

    assign fmt_o      = out_q.geom.fmt;
    assign bytes_pp_o = out_q.geom.bytes;
    assign width_o    = out_q.geom.width;
    assign height_o   = out_q.geom.height;
    assign stride_o   = out_q.geom.stride;
    assign offset_o   = out_q.geom.offset;
    assign size_o     = out_q.geom.size;
    assign mode_ok_o  = out_q.ok;
    assign mode_chg_o = trk_chg;

endmodule

// File: rtl/fbv_checker.sv
module fbv_checker #(
    parameter int unsigned REG_W   = 16,
    parameter int unsigned CALC_W  = 64,
    parameter int unsigned MIN_DIM = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CALC_W-1:0] vmem_bytes_i,
    input logic [1:0]        fmt_o,
    input logic [2:0]        bytes_pp_o,
    input logic [REG_W-1:0]  width_o,
    input logic [REG_W-1:0]  height_o,
    input logic [CALC_W-1:0] stride_o,
    input logic [CALC_W-1:0] offset_o,
    input logic [CALC_W-1:0] size_o,
    input logic              mode_ok_o,
    input logic              mode_chg_o
);

    localparam int unsigned PAD_W = CALC_W - REG_W;

    assert_zero_when_bad_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_ok_o |-> (fmt_o == 2'd0 && bytes_pp_o == 3'd0 && width_o == '0 &&
                        height_o == '0 && stride_o == '0 && offset_o == '0 && size_o == '0));

    assert_chg_needs_ok_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg_o |-> mode_ok_o);

    assert_no_repeat_chg_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_chg_o ##1 (mode_ok_o && $stable({fmt_o, bytes_pp_o, width_o, height_o,
                                                  stride_o, offset_o, size_o})))
        |-> !mode_chg_o);

    assert_fits_memory_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_ok_o |-> (offset_o + size_o <= $past(vmem_bytes_i)));

    assert_min_dims_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_ok_o |-> (width_o >= REG_W'(MIN_DIM) && height_o >= REG_W'(MIN_DIM)));

    assert_stride_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_ok_o |-> (stride_o >= {{PAD_W{1'b0}}, width_o} * CALC_W'(bytes_pp_o)));

    assert_bytes_match_fmt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_ok_o |-> ((fmt_o == 2'd1 && bytes_pp_o == 3'd2) ||
                       (fmt_o[1] && bytes_pp_o == 3'd4)));

endmodule

bind fbmode_validator fbv_checker #(
    .REG_W   (REG_W),
    .CALC_W  (CALC_W),
    .MIN_DIM (MIN_DIM)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vmem_bytes_i (vmem_bytes_i),
    .fmt_o        (fmt_o),
    .bytes_pp_o   (bytes_pp_o),
    .width_o      (width_o),
    .height_o     (height_o),
    .stride_o     (stride_o),
    .offset_o     (offset_o),
    .size_o       (size_o),
    .mode_ok_o    (mode_ok_o),
    .mode_chg_o   (mode_chg_o)
);

// File: tb/fbmode_validator_tb_top.sv
module fbmode_validator_tb_top;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned CALC_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_W-1:0]  en_word = '0, bpp = '0, xres = '0, yres = '0;
    logic [REG_W-1:0]  vwidth = '0, xoff = '0, yoff = '0;
    logic              be = 1'b0;
    logic [CALC_W-1:0] vmem = '0;
    logic [1:0]        fmt;
    logic [2:0]        bpx;
    logic [REG_W-1:0]  wid, hgt;
    logic [CALC_W-1:0] stride, offs, size;
    logic              ok, chg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fbmode_validator dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_word_i(en_word), .bpp_i(bpp),
        .xres_i(xres), .yres_i(yres), .vwidth_i(vwidth), .xoff_i(xoff),
        .yoff_i(yoff), .be_order_i(be), .vmem_bytes_i(vmem),
        .fmt_o(fmt), .bytes_pp_o(bpx), .width_o(wid), .height_o(hgt),
        .stride_o(stride), .offset_o(offs), .size_o(size),
        .mode_ok_o(ok), .mode_chg_o(chg)
    );

    typedef struct {
        longint unsigned f, b, w, h, st, of, sz, ok, chg;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    longint unsigned held[7] = '{default: 0};

    task automatic check_item(input exp_t e);
        longint unsigned act[9];
        longint unsigned ex[9];
        string nm[9] = '{"fmt", "bytes", "width", "height", "stride", "offset", "size", "ok", "chg"};
        bit miss = 1'b0;
        act = '{fmt, bpx, wid, hgt, stride, offs, size, ok, chg};
        ex  = '{e.f, e.b, e.w, e.h, e.st, e.of, e.sz, e.ok, e.chg};
        total++;
        for (int i = 0; i < 9; i++) begin
            if (act[i] != ex[i]) begin
                $display("FAIL %s %s actual=%0d expected=%0d", e.tag, nm[i], act[i], ex[i]);
                miss = 1'b1;
            end
        end
        if (miss) bad++;
    endtask

    // Driver: applies one input set per cycle and queues the expected result.
    task automatic drive(input int unsigned en_v, input int unsigned bpp_v,
                         input int unsigned xr, input int unsigned yr,
                         input int unsigned vw, input int unsigned xo,
                         input int unsigned yo, input bit be_v,
                         input longint unsigned vm, input string tag);
        exp_t e;
        longint unsigned nb, ew, st, sz, of;
        bit good;
        @(negedge clk);
        en_word = REG_W'(en_v); bpp = REG_W'(bpp_v); xres = REG_W'(xr);
        yres = REG_W'(yr); vwidth = REG_W'(vw); xoff = REG_W'(xo);
        yoff = REG_W'(yo); be = be_v; vmem = vm;
        nb   = (bpp_v == 16) ? 2 : (bpp_v == 32) ? 4 : 0;
        ew   = (vw < xr) ? xr : vw;
        st   = ew * nb;
        sz   = st * yr;
        of   = xo * nb + yo * st;
        good = en_v[0] && nb != 0 && xr >= 64 && yr >= 64 && (of + sz) <= vm;
        e = '{default: 0, tag: tag};
        if (good) begin
            e.f  = (nb == 2) ? 1 : (be_v ? 3 : 2);
            e.b  = nb; e.w = xr; e.h = yr; e.st = st; e.of = of; e.sz = sz; e.ok = 1;
            if ('{e.f, e.b, e.w, e.h, e.st, e.of, e.sz} != held) begin
                e.chg = 1;
                held  = '{e.f, e.b, e.w, e.h, e.st, e.of, e.sz};
            end
        end
        exp_q.push_back(e);
    endtask

    // Monitor: one result per cycle, sampled 1 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check_item(exp_q.pop_front());
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam longint unsigned MEM16 = 64'h100_0000;
    localparam longint unsigned MEM4  = 64'h40_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (ok || chg || size != 0 || fmt != 0 || stride != 0) begin
            bad++;
            $display("FAIL R1 actual=ok%0d chg%0d size%0d expected=all zero", ok, chg, size);
        end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        total++;
        if (ok || chg || size != 0 || wid != 0) begin
            bad++;
            $display("FAIL R1 post-reset actual=ok%0d size%0d expected=0", ok, size);
        end
        drive(0,  32, 640, 480, 640, 0, 0, 0, MEM16, "R2 disabled");
        drive(1,  32, 640, 480, 640, 0, 0, 0, MEM16, "R3 xrgb le / R11 first");
        drive(1,  32, 640, 480, 640, 0, 0, 0, MEM16, "R11 repeat no strobe");
        drive(1,  32, 640, 480, 640, 0, 0, 1, MEM16, "R3 xrgb be");
        drive(1,  16, 800, 600, 800, 0, 0, 0, MEM16, "R3 rgb565");
        drive(1,  24, 800, 600, 800, 0, 0, 0, MEM16, "R4 bad bpp R10");
        drive(1,  8,  800, 600, 800, 0, 0, 0, MEM16, "R4 bpp 8");
        drive(1,  16, 800, 600, 100, 0, 0, 0, MEM16, "R5 vwidth clamp");
        drive(1,  16, 800, 600, 1024, 0, 0, 0, MEM16, "R5 R6 wide stride");
        drive(1,  16, 800, 600, 1024, 8, 4, 0, MEM16, "R7 offset");
        drive(1,  32, 63, 480, 63, 0, 0, 0, MEM16, "R8 width 63");
        drive(1,  32, 640, 63, 640, 0, 0, 0, MEM16, "R8 height 63");
        drive(1,  32, 64, 64, 64, 0, 0, 0, MEM16, "R8 exactly 64");
        drive(1,  32, 1024, 1024, 1024, 0, 0, 0, MEM4, "R9 exact fit");
        drive(1,  32, 1024, 1024, 1024, 0, 1, 0, MEM4, "R9 overflow R10");
        drive(1,  32, 1024, 1024, 1024, 0, 0, 0, MEM4, "R11 return after invalid");
        drive(16'h41, 32, 1024, 1024, 1024, 0, 0, 0, MEM4, "R2 extra bits ignored");
        drive(16'hfffe, 32, 1024, 1024, 1024, 0, 0, 0, MEM4, "R2 bit0 clear");
        drive(1,  16, 320, 200, 320, 0, 0, 0, MEM16, "R12 back to back a");
        drive(1,  32, 320, 200, 320, 0, 0, 0, MEM16, "R12 back to back b");
        drive(1,  32, 320, 200, 320, 0, 0, 0, MEM16, "R12 back to back c");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule